// File: doc/BRIEF.md
# Atomic Memory Swap Controller

This block exchanges a register value with one memory location as a single indivisible operation. A one-cycle start strobe hands it a byte address, a source value and a size select (word or byte). The block reads the addressed location, writes the source value back to the same location, and then returns the contents it read. The returned value is always the memory contents from before the write.

The memory side is a single-port request/grant interface. A request is accepted in any cycle where both `mem_req_o` and `mem_gnt_i` are high. Read data comes back on `mem_rvalid_i` one or more cycles after the read is accepted. While the exchange is in flight, `lock_o` tells the bus fabric to keep every other master off the memory. The block samples all start inputs when it accepts the strobe. The source register can therefore also be the destination register, which gives a true exchange.

Top module: `swap_ctrl`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `lock_o`, `mem_req_o` and `mem_we_o` are low and `dst_o` is zero.
- R2: A word swap returns the old word on `dst_o` and leaves the source value in memory. For example, memory 0x12345678 and source 0x11112222 give `dst_o` = 0x12345678 and memory 0x11112222.
- R3: A byte swap (`byte_i` = 1) uses the lane numbered by the low two address bits, with lane k being data bits 8k+7..8k. It writes source bits 7..0 into that lane only, with exactly one bit of `mem_be_o` set. It returns that lane's old byte zero-extended on `dst_o`.
- R4: A word swap (`byte_i` = 0) sets every bit of `mem_be_o` and ignores the low two address bits. `mem_addr_o` is the byte address shifted right by two.
- R5: Each swap issues exactly one read and then one write to the same address. The write is requested only after the read data has returned.
- R6: `lock_o` is high from the first cycle the read is requested until the cycle the write is accepted, inclusive. It is low in every other cycle.
- R7: Address, source and size are captured when the start strobe is accepted. Changes on those inputs during the swap have no effect.
- R8: A start strobe that arrives while the block is busy is ignored. It causes no memory access and no later swap.
- R9: `done_o` is a one-cycle pulse. `dst_o` changes only in the cycle `done_o` is high and holds its value until the next completion.
- R10: The block waits for any number of grant wait cycles and any read latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| byte_i | input | 1 | 1 = byte swap, 0 = word swap |
| addr_i | input | AW | Byte address |
| src_i | input | DW | Value to write to memory |
| busy_o | output | 1 | Swap in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | DW | Old memory contents of the last completed swap |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW-2 | Word address |
| mem_be_o | output | DW/8 | Byte-lane write enables |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| lock_o | output | 1 | Keep other masters off the bus |

## Verification
Some properties are checked on every cycle by assertions:
- `lock_o` covers every request and is low when idle.
- A write request never starts without read data having just returned.
- `done_o` lasts exactly one cycle and `dst_o` never changes outside it.
- The request address and byte enables stay constant while a request waits for its grant.
- The byte enables are one-hot in byte mode and all set in word mode.

Other behaviour can only be shown by the bench's scenarios:
- The values actually exchanged, including the lane chosen and the zero extension.
- That a start arriving while busy leaves other memory untouched.
- That input changes after acceptance have no effect.
- That two swaps with the result fed back restore memory.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } swap_state_e;
endpackage

// File: rtl/swap_capture.sv
module swap_capture #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] src_i,
  input  logic          byte_i,
  output logic [AW-1:0] addr_q_o,
  output logic [DW-1:0] src_q_o,
  output logic          byte_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      src_q_o  <= '0;
      byte_q_o <= 1'b0;
    end else if (load_i) begin
      addr_q_o <= addr_i;
      src_q_o  <= src_i;
      byte_q_o <= byte_i;
    end
  end
endmodule

// File: rtl/swap_lanes.sv
module swap_lanes #(
  parameter int DW = 32,
  localparam int LW = DW / 8,
  localparam int LS = $clog2(LW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_i,
  input  logic [LS-1:0] lane_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] rdata_i,
  output logic [LW-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rext_o
);
  logic [7:0] rbytes [LW];

  for (genvar g = 0; g < LW; g++) begin : g_lane
    localparam logic [LS-1:0] IDX = LS'(g);
    assign be_o[g]          = byte_i ? (lane_i == IDX) : 1'b1;
    assign wdata_o[g*8 +: 8] = byte_i ? src_i[7:0] : src_i[g*8 +: 8];
    assign rbytes[g]        = rdata_i[g*8 +: 8];
  end

  assign rext_o = byte_i ? {{(DW-8){1'b0}}, rbytes[lane_i]} : rdata_i;

  // R3
  byte_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> ($countones(be_o) == 1));
  // R4
  word_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |-> (&be_o));
endmodule

// File: rtl/swap_fsm.sv
module swap_fsm
  import swap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rext_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o,
  output logic          lock_o,
  output logic          done_o,
  output logic [DW-1:0] dst_o
);
  swap_state_e state_q, state_d;
  logic [DW-1:0] rd_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_READ;
      ST_READ:  if (gnt_i)    state_d = ST_WAIT;
      ST_WAIT:  if (rvalid_i) state_d = ST_WRITE;
      ST_WRITE: if (gnt_i)    state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // old data parked until the write lands, then published with done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      dst_o <= '0;
    end else begin
      if (state_q == ST_WAIT && rvalid_i) rd_q <= rext_i;
      if (state_q == ST_WRITE && gnt_i)   dst_o <= rd_q;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign busy_o = (state_q != ST_IDLE);
  assign req_o  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign we_o   = (state_q == ST_WRITE);
  assign lock_o = (state_q == ST_READ) || (state_q == ST_WAIT) || (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);

  // R6
  lock_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> lock_o);
  // R6
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || done_o) |-> !lock_o);
  // R5
  write_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o && !$past(req_o && we_o)) |-> $past(rvalid_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dst_o) |-> done_o);
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int LW = DW / 8,
  localparam int LS = $clog2(LW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          byte_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] src_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] dst_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-LS-1:0] mem_addr_o,
  output logic [LW-1:0] mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          lock_o
);
  logic          load;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] src_q;
  logic          byte_q;
  logic [DW-1:0] rext;
  logic [LW-1:0] be;

  swap_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .addr_i   (addr_i),
    .src_i    (src_i),
    .byte_i   (byte_i),
    .addr_q_o (addr_q),
    .src_q_o  (src_q),
    .byte_q_o (byte_q)
  );

  swap_lanes #(.DW(DW)) u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (byte_q),
    .lane_i  (addr_q[LS-1:0]),
    .src_i   (src_q),
    .rdata_i (mem_rdata_i),
    .be_o    (be),
    .wdata_o (mem_wdata_o),
    .rext_o  (rext)
  );

  swap_fsm #(.DW(DW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .gnt_i    (mem_gnt_i),
    .rvalid_i (mem_rvalid_i),
    .rext_i   (rext),
    .load_o   (load),
    .busy_o   (busy_o),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .lock_o   (lock_o),
    .done_o   (done_o),
    .dst_o    (dst_o)
  );

  assign mem_addr_o = addr_q[AW-1:LS];
  assign mem_be_o   = be;

  // R7
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o) && !$past(mem_gnt_i))
      |-> ($stable(mem_addr_o) && $stable(mem_be_o) && $stable(mem_we_o)));
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/swap_ctrl_test.sv
`timescale 1ns/1ps
module swap_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] src = '0;
  logic busy, done, mem_req, mem_we, lock;
  logic [DW-1:0] dst, mem_wdata;
  logic [AW-3:0] mem_addr;
  logic [3:0] mem_be;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int errors = 0, checks = 0;
  int gnt_dly = 0, rd_lat = 0;
  logic [31:0] mem [16];

  always #2 clk = ~clk;

  swap_ctrl #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byt),
    .addr_i(addr), .src_i(src), .busy_o(busy), .done_o(done), .dst_o(dst),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .lock_o(lock)
  );

  // bus monitor: acceptances, lock window, ordering
  logic acc = 0, acc_we = 0, win = 0;
  logic [AW-3:0] acc_addr = '0, last_rd = '0;
  logic [3:0] acc_be = '0;
  logic [31:0] acc_wdata = '0;
  int lock_err = 0, order_err = 0, rd_acc = 0, wr_acc = 0;

  always @(posedge clk) begin
    acc       <= mem_req && mem_gnt;
    acc_we    <= mem_we;
    acc_addr  <= mem_addr;
    acc_be    <= mem_be;
    acc_wdata <= mem_wdata;
    if (rst_n) begin
      if (mem_req && !lock) lock_err <= lock_err + 1;
      if (win && !lock) lock_err <= lock_err + 1;
      if (!win && !mem_req && lock) lock_err <= lock_err + 1;
      if (mem_req && mem_gnt) begin
        if (!mem_we) begin
          rd_acc <= rd_acc + 1;
          last_rd <= mem_addr;
          win <= 1'b1;
          if (win) order_err <= order_err + 1;
        end else begin
          wr_acc <= wr_acc + 1;
          win <= 1'b0;
          if (!win || mem_addr != last_rd) order_err <= order_err + 1;
        end
      end
    end
  end

  // memory model, updated away from the active edge
  logic rd_pend = 0;
  int rd_cnt = 0, gcnt = 0;
  logic [31:0] rd_data = '0;
  always @(negedge clk) begin
    if (acc) begin
      if (acc_we) begin
        for (int b = 0; b < 4; b++)
          if (acc_be[b]) mem[acc_addr[3:0]][b*8 +: 8] = acc_wdata[b*8 +: 8];
      end else begin
        rd_pend = 1'b1;
        rd_cnt  = rd_lat;
        rd_data = mem[acc_addr[3:0]];
      end
    end
    mem_rvalid = 1'b0;
    if (rd_pend) begin
      if (rd_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_data;
        rd_pend    = 1'b0;
      end else rd_cnt--;
    end
    if (mem_req) begin
      if (gcnt >= gnt_dly) mem_gnt = 1'b1;
      else begin
        gcnt++;
        mem_gnt = 1'b0;
      end
    end else begin
      mem_gnt = 1'b0;
      gcnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [AW-1:0] a, input logic [31:0] s, input logic b);
    @(negedge clk);
    addr = a; src = s; byt = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin
        got = 1;
        break;
      end
    end
  endtask

  function automatic logic [31:0] exp_dst(logic [31:0] old, logic [AW-1:0] a, logic b);
    return b ? {24'h0, old[a[1:0]*8 +: 8]} : old;
  endfunction

  function automatic logic [31:0] exp_mem(logic [31:0] old, logic [AW-1:0] a, logic [31:0] s, logic b);
    logic [31:0] r;
    r = old;
    if (b) r[a[1:0]*8 +: 8] = s[7:0];
    else   r = s;
    return r;
  endfunction

  // one complete swap with checks on result, memory, pulse, lock and ordering
  task automatic run_swap(input string tag, input logic [AW-1:0] a, input logic [31:0] s, input logic b);
    logic [31:0] old, ed, em;
    int r0, w0;
    bit got;
    old = mem[a[5:2]];
    ed = exp_dst(old, a, b);
    em = exp_mem(old, a, s, b);
    r0 = rd_acc; w0 = wr_acc;
    do_start(a, s, b);
    wait_done(got);
    check(got, {tag, " R10 completion"}, 32'(got), 32'd1);
    check(dst == ed, {tag, " dst"}, dst, ed);
    @(negedge clk);
    check(!done, {tag, " R9 done pulse"}, 32'(done), 32'd0);
    check(mem[a[5:2]] == em, {tag, " memory"}, mem[a[5:2]], em);
    check(rd_acc - r0 == 1 && wr_acc - w0 == 1 && order_err == 0,
          {tag, " R5 one read then one write"}, 32'(order_err), 32'd0);
    check(lock_err == 0 && !lock, {tag, " R6 lock window"}, 32'(lock_err), 32'd0);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check(!busy && !done && !lock && !mem_req && !mem_we && dst == 0, "R1 in reset",
          {busy, done, lock, mem_req, mem_we}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !lock && !mem_req && !mem_we && dst == 0, "R1 after reset",
          {busy, done, lock, mem_req, mem_we}, 32'd0);
  endtask

  task automatic t_word_example;
    gnt_dly = 0; rd_lat = 0;
    mem[1] = 32'h12345678;
    run_swap("R2 word", 16'h0004, 32'h11112222, 1'b0);
    check(dst == 32'h12345678, "R2 returned word", dst, 32'h12345678);
    check(mem[1] == 32'h11112222, "R2 stored word", mem[1], 32'h11112222);
  endtask

  task automatic t_word_unaligned;
    mem[2] = 32'hCAFEF00D;
    run_swap("R4 unaligned word", 16'h000B, 32'h0BADBEEF, 1'b0);
    check(mem[2] == 32'h0BADBEEF, "R4 all lanes written", mem[2], 32'h0BADBEEF);
  endtask

  task automatic t_byte_lanes;
    mem[3] = 32'hA1B2C3D4;
    for (int k = 0; k < 4; k++)
      run_swap($sformatf("R3 byte lane %0d", k), 16'(16'h000C + k), 32'hFFFFFF50 + k, 1'b1);
    check(mem[3] == 32'h53525150, "R3 all lanes replaced", mem[3], 32'h53525150);
    check(dst == 32'h000000A1, "R3 zero-extended top lane", dst, 32'h000000A1);
  endtask

  task automatic t_latency;
    gnt_dly = 3; rd_lat = 4;
    mem[4] = 32'h01234567;
    run_swap("R10 slow word", 16'h0010, 32'h89ABCDEF, 1'b0);
    gnt_dly = 2; rd_lat = 6;
    mem[5] = 32'h00FF7700;
    run_swap("R10 slow byte", 16'h0016, 32'h00000099, 1'b1);
    gnt_dly = 0; rd_lat = 0;
  endtask

  task automatic t_capture;
    bit got;
    mem[6] = 32'h13572468;
    mem[7] = 32'h55555555;
    gnt_dly = 2; rd_lat = 2;
    do_start(16'h0018, 32'hFEEDFACE, 1'b0);
    addr = 16'h001C; src = 32'h0; byt = 1'b1;
    wait_done(got);
    check(dst == 32'h13572468, "R7 captured address", dst, 32'h13572468);
    @(negedge clk); @(negedge clk);
    check(mem[6] == 32'hFEEDFACE, "R7 captured source and size", mem[6], 32'hFEEDFACE);
    check(mem[7] == 32'h55555555, "R7 new address untouched", mem[7], 32'h55555555);
    gnt_dly = 0; rd_lat = 0;
  endtask

  task automatic t_busy_start;
    bit got;
    int r0;
    logic [31:0] prev;
    mem[8] = 32'h0000AAAA;
    mem[9] = 32'h0000BBBB;
    gnt_dly = 3; rd_lat = 3;
    prev = dst;
    r0 = rd_acc;
    do_start(16'h0020, 32'h0000CCCC, 1'b0);
    @(negedge clk);
    check(dst == prev, "R9 dst held mid-swap", dst, prev);
    addr = 16'h0024; src = 32'h0000DDDD; byt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    check(dst == 32'h0000AAAA, "R8 first swap result", dst, 32'h0000AAAA);
    repeat (10) @(negedge clk);
    check(!busy && rd_acc - r0 == 1, "R8 no second swap", 32'(rd_acc - r0), 32'd1);
    check(mem[9] == 32'h0000BBBB, "R8 other word untouched", mem[9], 32'h0000BBBB);
    check(dst == 32'h0000AAAA, "R9 dst held after done", dst, 32'h0000AAAA);
    gnt_dly = 0; rd_lat = 0;
  endtask

  task automatic t_exchange;
    logic [31:0] first;
    mem[10] = 32'h76543210;
    run_swap("R2 exchange out", 16'h0028, 32'h0F0F0F0F, 1'b0);
    first = dst;
    run_swap("R2 exchange back", 16'h0028, first, 1'b0);
    check(mem[10] == 32'h76543210 && dst == 32'h0F0F0F0F, "R2 exchange restores",
          mem[10], 32'h76543210);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'(i) * 32'h01010101;
    t_reset();
    t_word_example();
    t_word_unaligned();
    t_byte_lanes();
    t_latency();
    t_capture();
    t_busy_start();
    t_exchange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule